// File: doc/BRIEF.md
# Accumulator Readout Scaler and Limiter

This block sits between a wide two's-complement accumulator and a 24-bit data bus. On a read strobe it takes a window of the 56-bit accumulator as the bus word. The accumulator is an 8-bit extension above a 24-bit high word and a 24-bit low word. The window is the high word, or the high word after a one-bit right or left shift, as a stored scaling mode selects. When the shifted value does not fit in 24 signed bits, the block puts the largest positive or negative bus word on the bus instead. The bus word and a valid pulse appear one clock after the strobe.

The block also keeps two sticky status flags. The growth flag records, on each read, whether two adjacent accumulator bits differ. Which pair it tests depends on the scaling mode. The limit flag records an external overflow indication, any saturation the readout itself performed, and, when arithmetic saturation is enabled, an external saturation event. Both flags hold until a clear command or reset. The block also presents the rounding bit position the multiply-accumulate unit must use under the current mode.

Top module: `acc_bus_scaler`

## Requirements
- R1: The scaling mode register resets to 00 and loads `mode_in` on a clock with `mode_wr` high. Mode codes: 00 = no shift, 01 = shift right by one, 10 = shift left by one, 11 = reserved. `rnd_pos` shows 23 for 00, 24 for 01, 22 for 10 and 23 for 11.
- R2: A clock edge with `rd_stb` high makes `bus_vld` high for the following cycle and loads `bus_out`. With mode 00, `bus_out` is accumulator bits [47:24]. Without `rd_stb`, `bus_vld` is low and `bus_out` holds.
- R3: With mode 01, `bus_out` is bits [48:25]. With mode 10 it is bits [46:23]. Mode 11 reads exactly as mode 00.
- R4: If the accumulator, arithmetically shifted right by 24 (mode 00/11), 25 (mode 01) or 23 (mode 10), lies outside -8388608..8388607, `bus_out` is 0x7FFFFF when bit 55 is 0 and 0x800000 when bit 55 is 1.
- R5: On a read, the growth flag `s_flag` is ORed with bit46 XOR bit45 in mode 00, with bit47 XOR bit46 in mode 01, and with bit45 XOR bit44 in mode 10. In mode 11 and on cycles without `rd_stb` it is left unchanged.
- R6: Once set, `s_flag` stays set across later reads whose tested bits are equal, until cleared.
- R7: `l_flag` is set by a read that saturates (R4) and by `ovf_in`. It is also set by `sat_evt` while `sat_mode` is 1. `sat_evt` has no effect while `sat_mode` is 0. Once set, `l_flag` stays set until cleared.
- R8: `flag_clr` clears both flags at the next edge and wins over any set condition in the same cycle.
- R9: During reset, `bus_out` is 0, `bus_vld` is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Load the scaling mode register |
| mode_in | input | 2 | New scaling mode code |
| acc_in | input | 56 | Accumulator value to read out |
| rd_stb | input | 1 | Read the accumulator onto the bus |
| ovf_in | input | 1 | Overflow indication, sets the limit flag |
| sat_mode | input | 1 | Arithmetic saturation enabled |
| sat_evt | input | 1 | Arithmetic saturation event |
| flag_clr | input | 1 | Clear both sticky flags |
| bus_out | output | 24 | Scaled, limited bus word |
| bus_vld | output | 1 | Bus word valid, one cycle after a read |
| s_flag | output | 1 | Sticky growth flag |
| l_flag | output | 1 | Sticky limit flag |
| rnd_pos | output | 6 | Rounding bit position for the current mode |

## Verification
The bench reads values that sit just inside and just outside the 24-bit range in every mode, in both signs. A limiter that tested the extension bits of the wrong mode would pass an overflowed word or clip a legal one. A wrong polarity choice would saturate to the opposite extreme. It picks accumulator patterns where only one of the three candidate bit pairs differs. A design that tested the wrong pair for the mode, or updated the growth flag in the reserved mode or without a read, would show a wrong flag. It also checks the sticky behaviour and clear priority. It exercises a saturation event while arithmetic saturation is off, which must leave the limit flag low. A design that let the event through anyway, or let a same-cycle set beat the clear, would leave a flag high.

// File: rtl/scl_pkg.sv
// Shared types for the accumulator readout scaler.
// Assumes a two-bit scaling mode code.
package scl_pkg;
    typedef enum logic [1:0] {
        SM_NONE = 2'b00,
        SM_DOWN = 2'b01,
        SM_UP   = 2'b10,
        SM_RSVD = 2'b11
    } scale_mode_e;
endpackage

// File: rtl/scl_shift_lim.sv
// Combinational shifter and limiter. Takes the upper part of the
// accumulator and forms the bus word for one of three shift amounts
// (left one, none, right one). It replaces the word by the signed
// extreme when the discarded upper bits are not all copies of the sign.
// Assumes ACC_W > 2*BUS_W and that the bits below BUS_W-1 are not needed.
module scl_shift_lim
    import scl_pkg::*;
#(
    parameter int ACC_W = 56,
    parameter int BUS_W = 24
) (
    input  logic [ACC_W-1:BUS_W-1] acc_hi,
    input  scale_mode_e            mode,
    output logic [BUS_W-1:0]       word,
    output logic                   limited
);
    localparam int NCAND = 3;

    logic [BUS_W-1:0] cand [NCAND];
    logic [NCAND-1:0] fits;
    logic             sign;
    int unsigned      sel;

    assign sign = acc_hi[ACC_W-1];

    // Candidate k takes the window starting at bit BUS_W-1+k.
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        localparam int LO = 2*BUS_W - 2 + k;
        logic [ACC_W-1-LO:0] ext;
        assign ext      = acc_hi[ACC_W-1:LO];
        assign cand[k]  = acc_hi[BUS_W-1+k +: BUS_W];
        assign fits[k]  = (&ext) | ~(|ext);
    end

    // Map the mode to a candidate index; reserved reads as no shift.
    always_comb begin
        case (mode)
            SM_UP:   sel = 0;
            SM_DOWN: sel = 2;
            default: sel = 1;
        endcase
    end

    // Choose the candidate word or the saturated extreme.
    always_comb begin
        limited = ~fits[sel];
        if (limited) word = {sign, {(BUS_W-1){~sign}}};
        else         word = cand[sel];
    end
endmodule

// File: rtl/scl_flags.sv
// Sticky growth and limit flags. The growth flag tests one adjacent pair
// in a four-bit window of the accumulator (bits 2*BUS_W-1 down to
// 2*BUS_W-4), chosen by the mode. The limit flag gathers readout
// saturation and the external overflow and saturation-event inputs.
// The clear command has priority over every set condition.
module scl_flags
    import scl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_stb,
    input  scale_mode_e mode,
    input  logic [3:0]  win,
    input  logic        limited,
    input  logic        ovf_in,
    input  logic        sat_mode,
    input  logic        sat_evt,
    input  logic        flag_clr,
    output logic        s_flag,
    output logic        l_flag
);
    logic s_hit;
    logic l_hit;

    // Pick the pair tested for growth under the current mode.
    always_comb begin
        case (mode)
            SM_NONE: s_hit = win[2] ^ win[1];
            SM_DOWN: s_hit = win[3] ^ win[2];
            SM_UP:   s_hit = win[1] ^ win[0];
            default: s_hit = 1'b0;
        endcase
    end

    assign l_hit = (rd_stb & limited) | ovf_in | (sat_mode & sat_evt);

    // Growth flag: ORs in the pair test on each read, cleared on command.
    always_ff @(posedge clk) begin
        if (!rst_n)        s_flag <= 1'b0;
        else if (flag_clr) s_flag <= 1'b0;
        else if (rd_stb)   s_flag <= s_flag | s_hit;
    end

    // Limit flag: latches any limit source, cleared on command.
    always_ff @(posedge clk) begin
        if (!rst_n)        l_flag <= 1'b0;
        else if (flag_clr) l_flag <= 1'b0;
        else               l_flag <= l_flag | l_hit;
    end
endmodule

// File: rtl/acc_bus_scaler.sv
// Top level of the accumulator readout scaler. It holds the scaling mode,
// registers the scaled and limited bus word with a valid pulse, and
// reports the rounding position for the current mode. Reset is
// synchronous and active low. Assumes ACC_W > 2*BUS_W.
module acc_bus_scaler
    import scl_pkg::*;
#(
    parameter int ACC_W = 56,
    parameter int BUS_W = 24,
    localparam int RP_W = $clog2(ACC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [1:0]       mode_in,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             rd_stb,
    input  logic             ovf_in,
    input  logic             sat_mode,
    input  logic             sat_evt,
    input  logic             flag_clr,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_vld,
    output logic             s_flag,
    output logic             l_flag,
    output logic [RP_W-1:0]  rnd_pos
);
    scale_mode_e      mode_q;
    logic [BUS_W-1:0] word;
    logic             limited;
    logic             unused_lo;

    assign unused_lo = ^acc_in[BUS_W-2:0];

    // Scaling mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= SM_NONE;
        else if (mode_wr) mode_q <= scale_mode_e'(mode_in);
    end

    scl_shift_lim #(.ACC_W(ACC_W), .BUS_W(BUS_W)) u_shift (
        .acc_hi  (acc_in[ACC_W-1:BUS_W-1]),
        .mode    (mode_q),
        .word    (word),
        .limited (limited)
    );

    scl_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .mode     (mode_q),
        .win      (acc_in[2*BUS_W-1 -: 4]),
        .limited  (limited),
        .ovf_in   (ovf_in),
        .sat_mode (sat_mode),
        .sat_evt  (sat_evt),
        .flag_clr (flag_clr),
        .s_flag   (s_flag),
        .l_flag   (l_flag)
    );

    // Output register: captures the bus word on a read, pulses valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out <= '0;
            bus_vld <= 1'b0;
        end else begin
            bus_vld <= rd_stb;
            if (rd_stb) bus_out <= word;
        end
    end

    // Rounding position tracks the shift of the readout window.
    always_comb begin
        case (mode_q)
            SM_DOWN: rnd_pos = RP_W'(BUS_W);
            SM_UP:   rnd_pos = RP_W'(BUS_W - 2);
            default: rnd_pos = RP_W'(BUS_W - 1);
        endcase
    end
endmodule

// File: rtl/acc_bus_scaler_chk.sv
// Assertion checker for acc_bus_scaler, attached with bind below.
// Observes only the top-level ports.
module acc_bus_scaler_chk #(
    parameter int BUS_W = 24,
    parameter int RP_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [1:0]       mode_in,
    input logic             rd_stb,
    input logic             ovf_in,
    input logic             sat_mode,
    input logic             sat_evt,
    input logic             flag_clr,
    input logic [BUS_W-1:0] bus_out,
    input logic             bus_vld,
    input logic             s_flag,
    input logic             l_flag,
    input logic [RP_W-1:0]  rnd_pos
);
    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> bus_vld);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!bus_vld && $stable(bus_out)));
    // R5
    s_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_flag) |-> $past(rd_stb && !flag_clr));
    // R6
    s_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_flag && !flag_clr) |=> s_flag);
    // R7
    l_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_flag && !flag_clr) |=> l_flag);
    // R7
    l_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_flag) |-> $past(rd_stb || ovf_in || (sat_mode && sat_evt)));
    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!s_flag && !l_flag));
    // R1
    rnd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_in == 2'b01) |=> (rnd_pos == RP_W'(BUS_W)));
endmodule

bind acc_bus_scaler acc_bus_scaler_chk #(.BUS_W(BUS_W), .RP_W(RP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .mode_in  (mode_in),
    .rd_stb   (rd_stb),
    .ovf_in   (ovf_in),
    .sat_mode (sat_mode),
    .sat_evt  (sat_evt),
    .flag_clr (flag_clr),
    .bus_out  (bus_out),
    .bus_vld  (bus_vld),
    .s_flag   (s_flag),
    .l_flag   (l_flag),
    .rnd_pos  (rnd_pos)
);

// File: tb/acc_bus_scaler_test.sv
module acc_bus_scaler_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_in = 2'b00;
    logic [55:0] acc_in = '0;
    logic        rd_stb = 1'b0;
    logic        ovf_in = 1'b0;
    logic        sat_mode = 1'b0;
    logic        sat_evt = 1'b0;
    logic        flag_clr = 1'b0;
    logic [23:0] bus_out;
    logic        bus_vld;
    logic        s_flag;
    logic        l_flag;
    logic [5:0]  rnd_pos;

    int checks = 0;
    int errors = 0;
    bit exp_s = 0;
    bit exp_l = 0;
    logic [1:0] cur_mode = 2'b00;
    logic [23:0] exp_q [$];
    string tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_bus_scaler uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .acc_in(acc_in), .rd_stb(rd_stb), .ovf_in(ovf_in),
        .sat_mode(sat_mode), .sat_evt(sat_evt), .flag_clr(flag_clr),
        .bus_out(bus_out), .bus_vld(bus_vld), .s_flag(s_flag),
        .l_flag(l_flag), .rnd_pos(rnd_pos)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: arithmetic shift and range test (R3, R4).
    function automatic logic [23:0] mdl_word(input logic [55:0] a,
                                             input logic [1:0] m,
                                             output bit sat);
        longint v, q;
        int sh;
        v  = longint'($signed(a));
        sh = (m == 2'b01) ? 25 : (m == 2'b10) ? 23 : 24;
        q  = v >>> sh;
        sat = 1'b0;
        if (q > 64'sd8388607)       begin sat = 1'b1; return 24'h7FFFFF; end
        else if (q < -64'sd8388608) begin sat = 1'b1; return 24'h800000; end
        return q[23:0];
    endfunction

    // Reference growth test per mode (R5).
    function automatic bit mdl_s(input logic [55:0] a, input logic [1:0] m);
        case (m)
            2'b00:   return a[46] ^ a[45];
            2'b01:   return a[47] ^ a[46];
            2'b10:   return a[45] ^ a[44];
            default: return 1'b0;
        endcase
    endfunction

    task automatic set_mode(input logic [1:0] m);
        mode_in = m; mode_wr = 1'b1;
        @(posedge clk); #1;
        mode_wr = 1'b0; cur_mode = m;
    endtask

    // Driver: one read, expected word pushed to the scoreboard.
    task automatic do_read(input logic [55:0] a, input string tag);
        bit sat;
        logic [23:0] w;
        w = mdl_word(a, cur_mode, sat);
        exp_q.push_back(w);
        tag_q.push_back(tag);
        exp_s = exp_s | mdl_s(a, cur_mode);
        exp_l = exp_l | sat;
        acc_in = a; rd_stb = 1'b1;
        @(posedge clk); #1;
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_flags(input string tag);
        @(negedge clk);
        chk({tag, " s_flag"}, s_flag, exp_s);
        chk({tag, " l_flag"}, l_flag, exp_l);
    endtask

    task automatic pulse(input bit o, input bit sm, input bit se, input bit cl);
        ovf_in = o; sat_mode = sm; sat_evt = se; flag_clr = cl;
        @(posedge clk); #1;
        ovf_in = 0; sat_mode = 0; sat_evt = 0; flag_clr = 0;
        if (cl) begin exp_s = 0; exp_l = 0; end
        else exp_l = exp_l | o | (sm & se);
    endtask

    // Monitor: pops and compares each valid bus word.
    always @(negedge clk) begin
        if (rst_n && bus_vld) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected valid", 1, 0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, bus_out, e);
            end
        end
    end

    bit done = 0;
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 bus_out", bus_out, 0);
        chk("R9 bus_vld", bus_vld, 0);
        chk("R9 s_flag", s_flag, 0);
        chk("R9 l_flag", l_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rnd_pos", rnd_pos, 23);

        // R2 plain readout
        do_read(56'h00_123456_789ABC, "R2 none positive");
        do_read(56'hFF_C00000_000000, "R2 none negative");
        chk_flags("R5 none");
        // R4 R7 overflow in no-shift mode
        do_read(56'h01_000000_000000, "R4 none pos sat");
        chk_flags("R7 read sat");
        pulse(0, 0, 0, 1);
        chk_flags("R8 clear");
        do_read(56'hFE_FFFFFF_000000, "R4 none neg sat");
        pulse(0, 0, 0, 1);

        // R3 shift right
        set_mode(2'b01);
        @(negedge clk);
        chk("R1 rnd_pos down", rnd_pos, 24);
        do_read(56'h00_FFFFFE_000000, "R3 down max fit");
        chk_flags("R5 down pair equal");
        do_read(56'h01_000000_000000, "R4 down pos sat");
        do_read(56'h00_400000_000000, "R3 down growth");
        chk_flags("R5 down pair differs");
        pulse(0, 0, 0, 1);

        // R3 shift left
        set_mode(2'b10);
        @(negedge clk);
        chk("R1 rnd_pos up", rnd_pos, 22);
        do_read(56'h00_200000_000000, "R3 up growth");
        chk_flags("R5 up pair differs");
        do_read(56'h00_000001_800000, "R3 up small");
        chk_flags("R6 sticky s");
        do_read(56'h00_400000_000000, "R4 up pos sat");
        do_read(56'hFF_BFFFFF_000000, "R4 up neg sat");
        chk_flags("R7 up sat");
        pulse(0, 0, 0, 1);

        // R3 R5 reserved mode: read as no shift, flag untouched
        set_mode(2'b11);
        @(negedge clk);
        chk("R1 rnd_pos rsvd", rnd_pos, 23);
        do_read(56'h00_200000_000000, "R3 rsvd as none");
        chk_flags("R5 rsvd no update");

        // R5 no read, no update
        set_mode(2'b00);
        acc_in = 56'h00_200000_000000;
        @(posedge clk); #1;
        chk_flags("R5 no strobe");
        chk("R2 no strobe vld", bus_vld, 0);

        // R7 external sources
        pulse(0, 0, 1, 0);
        chk_flags("R7 sat_evt ignored");
        pulse(0, 1, 1, 0);
        chk_flags("R7 sat_evt enabled");
        pulse(0, 0, 0, 1);
        pulse(1, 0, 0, 0);
        chk_flags("R7 ovf_in");
        // R8 clear wins over same-cycle set
        do_read(56'h00_200000_000000, "R2 set s");
        pulse(1, 1, 1, 1);
        chk_flags("R8 clear priority");

        repeat (2) @(negedge clk);
        chk("R2 scoreboard empty", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule